// File: doc/BRIEF.md
# General-Purpose Event Register Block

This block holds a small set of general-purpose event flags and their matching enable bits. It sits in a four-byte window of I/O space and drives one level-sensitive system control interrupt. External event inputs latch into the status flags. Software acknowledges a flag by writing a one to it. Software picks which flags may raise the interrupt through the enable bits. The interrupt stays high for as long as any flag is set together with its enable bit.

The host reaches the window through a plain I/O port. The port carries a byte address, four byte enables, read and write strobes, and a 32-bit data path. An access may be one, two or four bytes wide. Inside the block, each enabled byte lane is treated as its own single-byte operation on address `io_addr + lane`, in little-endian order. Because of this, an access that straddles the edge of the window touches only the bytes that fall inside it. The interrupt is recomputed from the stored bits after every write and after every event.

Top module: `gpe_block`

## Requirements
- R1: After reset, all status and enable bits are zero, `sci` is low and `io_rdata` is zero.
- R2: Byte lane k of `io_wdata` and `io_rdata` (bits 8k+7..8k) serves byte address `io_addr + k`. Each enabled lane is an independent single-byte access, so wide accesses are little-endian.
- R3: The window starts at address 0xAFE0 and is 4 bytes long. Offsets 0 and 1 hold status bits 7..0 and 15..8. Offsets 2 and 3 hold enable bits 7..0 and 15..8.
- R4: Writing a one to a status bit clears it. Writing a zero leaves it unchanged.
- R5: A high `evt_in[i]` at a clock edge sets status bit i. If a clear of the same bit happens in the same cycle, the set wins.
- R6: Enable bits are plain read/write storage. They change only when a write hits their byte.
- R7: After the edge that applies a write or an event, `sci` equals the OR of (status AND enable).
- R8: A read lane whose address lies outside the window returns 0xFF. A write lane outside the window changes nothing.
- R9: Read data is registered. It appears after the clock edge that samples `io_rd`, reflects the state before that edge, and holds until the next read. Lanes whose byte enable is low read 0x00. Reads never change any state.
- R10: When `io_rd` and `io_wr` are high together, the write is applied and the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Byte address of lane 0 |
| io_be | input | 4 | Byte-lane enables |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data, lane k in bits 8k+7..8k |
| io_rdata | output | 32 | Registered read data |
| evt_in | input | 16 | Event inputs, one per status bit |
| sci | output | 1 | Level-sensitive interrupt |

## Verification
All results are due one clock edge after their stimulus. Read data is captured at the edge that samples `io_rd`. Status, enable and `sci` update at the edge that samples the write or the event. The bench drives each operation on a falling edge and checks `io_rdata` and `sci` on the next falling edge. That timing lets one operation's results be compared against a model state advanced exactly once per operation. Reads are checked against the model state from before the operation, which also covers the read-during-write case.

// File: rtl/gpe_block.sv
module gpe_block #(
  parameter logic [15:0] BASE = 16'hAFE0,
  parameter int          HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       io_addr,
  input  logic [3:0]        io_be,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [31:0]       io_wdata,
  output logic [31:0]       io_rdata,
  input  logic [8*HALF-1:0] evt_in,
  output logic              sci
);
  localparam int WIN = 2 * HALF;
  localparam int NEV = 8 * HALF;
  localparam int WB  = 8 * WIN;

  logic [WB-1:0]  win;
  logic [WB-1:0]  wmask, wval;
  logic [NEV-1:0] sts, en, sts_n, en_n;
  logic [31:0]    rd_n;
  logic [3:0]     hit;
  logic [15:0]    off [4];

  assign sts = win[NEV-1:0];
  assign en  = win[WB-1:NEV];

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign off[k] = io_addr + 16'(k) - BASE;
    assign hit[k] = off[k] < 16'(WIN);
  end

  always_comb begin
    wmask = '0;
    wval  = '0;
    for (int k = 0; k < 4; k++)
      if (io_wr && io_be[k] && hit[k])
        for (int j = 0; j < WIN; j++)
          if (off[k] == 16'(j)) begin
            wmask[8*j +: 8] = 8'hFF;
            wval[8*j +: 8]  = io_wdata[8*k +: 8];
          end
  end

  assign sts_n = (sts & ~(wmask[NEV-1:0] & wval[NEV-1:0])) | evt_in;
  assign en_n  = (en & ~wmask[WB-1:NEV]) | (wval[WB-1:NEV] & wmask[WB-1:NEV]);

  always_comb begin
    rd_n = '0;
    for (int k = 0; k < 4; k++)
      if (io_be[k]) begin
        rd_n[8*k +: 8] = 8'hFF;
        if (hit[k])
          for (int j = 0; j < WIN; j++)
            if (off[k] == 16'(j)) rd_n[8*k +: 8] = win[8*j +: 8];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win      <= '0;
      io_rdata <= '0;
    end else begin
      win <= {en_n, sts_n};
      if (io_rd) io_rdata <= rd_n;
    end
  end

  assign sci = |(sts & en);

  // R4
  sts_no_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> (($past(sts) & ~sts) == '0));
  // R5
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_in) |=> ((sts & $past(evt_in)) == $past(evt_in)));
  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(en));
  // R7
  sci_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sci) |-> ($past(io_wr) || $past(|evt_in)));
  // R8
  outside_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_be[0] && !hit[0]) |=> (io_rdata[7:0] == 8'hFF));
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));
endmodule

// File: tb/gpe_block_bench.sv
module gpe_block_bench;
  localparam logic [15:0] BASE = 16'hAFE0;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] io_addr = 0;
  logic [3:0]  io_be = 0;
  logic        io_rd = 0, io_wr = 0;
  logic [31:0] io_wdata = 0;
  logic [31:0] io_rdata;
  logic [15:0] evt_in = 0;
  logic        sci;
  int checks = 0, errors = 0;
  logic [31:0] m = 0;

  gpe_block u_gpe_block (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_be(io_be),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .evt_in(evt_in), .sci(sci));

  always #5 clk = ~clk;

  function automatic logic [31:0] f_read(logic [31:0] w, logic [15:0] a, logic [3:0] be);
    logic [31:0] r = 0;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] d = a + 16'(k) - BASE;
      if (be[k]) r[8*k +: 8] = (d < 4) ? w[8*d[1:0] +: 8] : 8'hFF;
    end
    return r;
  endfunction

  function automatic logic [31:0] f_next(logic [31:0] w, logic [15:0] a, logic [3:0] be,
                                         logic wr, logic [31:0] wd, logic [15:0] ev);
    logic [31:0] mk = 0, v = 0;
    logic [15:0] s;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] d = a + 16'(k) - BASE;
      if (wr && be[k] && d < 4) begin
        mk[8*d[1:0] +: 8] = 8'hFF;
        v[8*d[1:0] +: 8]  = wd[8*k +: 8];
      end
    end
    s = (w[15:0] & ~(mk[15:0] & v[15:0])) | ev;
    return {(w[31:16] & ~mk[31:16]) | (v[31:16] & mk[31:16]), s};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(string tag, logic [15:0] a, logic [3:0] be, logic rd, logic wr,
                    logic [31:0] wd, logic [15:0] ev);
    logic [31:0] er;
    io_addr = a; io_be = be; io_rd = rd; io_wr = wr; io_wdata = wd; evt_in = ev;
    er = f_read(m, a, be);
    m  = f_next(m, a, be, wr, wd, ev);
    @(posedge clk); @(negedge clk);
    io_rd = 0; io_wr = 0; evt_in = 0; io_be = 0;
    if (rd) check(tag, io_rdata, er);
    check("R7 sci", {31'd0, sci}, {31'd0, |(m[15:0] & m[31:16])});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 rdata", io_rdata, 0);
    check("R1 sci", {31'd0, sci}, 0);
    op("R1 window", BASE, 4'hF, 1, 0, 0, 0);
    op("R6 write en", BASE + 2, 4'b0011, 0, 1, 32'h0000_A55A, 0);
    op("R3 layout", BASE, 4'hF, 1, 0, 0, 0);
    op("R5 event", BASE, 0, 0, 0, 0, 16'h0002);
    op("R4 write zero", BASE, 4'b0001, 0, 1, 0, 0);
    op("R4 hold", BASE, 4'hF, 1, 0, 0, 0);
    op("R5 set wins", BASE, 4'b0001, 0, 1, 32'h02, 16'h0002);
    op("R5 kept", BASE, 4'hF, 1, 0, 0, 0);
    op("R4 clear", BASE, 4'b0001, 0, 1, 32'h02, 0);
    op("R4 cleared", BASE, 4'hF, 1, 0, 0, 0);
    op("R8 straddle read", BASE + 3, 4'hF, 1, 0, 0, 0);
    op("R8 straddle write", BASE - 1, 4'hF, 0, 1, 32'h1122_3344, 16'hFFFF);
    op("R2 lanes", BASE, 4'hF, 1, 0, 0, 0);
    op("R8 outside", BASE - 4, 4'hF, 1, 0, 0, 0);
    op("R9 disabled lane", BASE, 4'b0100, 1, 0, 0, 0);
    op("R9 repeat read", BASE, 4'hF, 1, 0, 0, 0);
    op("R9 repeat read", BASE, 4'hF, 1, 0, 0, 0);
    op("R10 rd with wr", BASE, 4'hF, 1, 1, 32'h5A5A_FFFF, 0);
    op("R10 after", BASE, 4'hF, 1, 0, 0, 0);
    for (int i = 0; i < 600; i++) begin
      logic [3:0]  be;
      logic [15:0] a, ev;
      case ($urandom % 5)
        0: be = 4'b0001; 1: be = 4'b0011; 2: be = 4'b1111;
        3: be = 4'b1100; default: be = 4'($urandom);
      endcase
      a  = BASE - 16'd4 + 16'($urandom % 12);
      ev = ($urandom % 4 == 0) ? 16'($urandom) & 16'($urandom) : 16'd0;
      op("R2 random", a, be, 1'($urandom), 1'($urandom), $urandom, ev);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule